// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block stores a stream of per-cycle trace words in an internal RAM that is used as a ring. While capture is enabled, each valid word passes through a one-entry staging register and is then written at the write pointer, which wraps at the end of the RAM. A trigger input marks the event of interest. After the trigger, a countdown register sets how many more words are written before the buffer freezes. That count fixes the split between history before the trigger and data after it.

Software controls the buffer through a small word-addressed register port. It can start, stop and restart capture, watch the flags, and set both pointers. It reads the stored words through a data port that advances the read pointer on each read. When the wrap flag is set, the oldest word sits at the write pointer. Without it, the valid words run from address 0 up to, but not including, the write pointer.

Top module: `trc_capbuf`

## Requirements
- R1: After reset, the control register (address 0), write pointer (address 2), read pointer (address 3) and countdown (address 5) read 0, and the flag register (address 1) reads 0x8. Flag bits are: bit 0 wrapped, bit 1 triggered, bit 2 complete, bit 3 staging empty.
- R2: Address 6 returns the RAM depth and address 7 returns the trace word width.
- R3: Capture is active while control bit 0 is set and the complete flag is clear. In that state, a word presented with its valid strobe is written one cycle later at the write pointer, and the pointer then advances modulo the depth.
- R4: The wrapped flag sets when a word is written at the last RAM address and stays set until capture is re-enabled.
- R5: The trigger input sets the triggered flag only while capture is active. A trigger while control bit 0 is clear changes no flag.
- R6: Once the triggered flag is set, every write decrements the countdown. The write that brings it to zero sets the complete flag, and no later write happens.
- R7: If the countdown is zero when the trigger is taken, the complete flag sets on the same clock edge as the triggered flag.
- R8: Flag bit 3 is high when the staging register holds no word. It is high on the cycle after the complete flag rises, and any staged word is dropped.
- R9: Writing 0 to the control register stops further writes and freezes the write pointer. The wrapped, triggered and complete flags keep their values.
- R10: A control write with bit 0 set clears the wrapped, triggered and complete flags.
- R11: Control bit 1 (demultiplexed port mode) is stored and read back only when the port width parameter is 8. Otherwise it reads 0.
- R12: The read pointer is writable. Each read of address 4 returns the RAM word at the read pointer and then advances the pointer modulo the depth.
- R13: The write pointer (address 2) and the countdown (address 5) can be written and read back. A software write takes priority over the capture logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_vld | input | 1 | Trace word valid |
| trc_word | input | WIDTH | Trace word |
| trc_trig | input | 1 | Trigger event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on address |

## Verification
The assertions take for granted these things about the inputs:
- Software does not load the write pointer or the countdown on the same cycle as a capture write it expects to see counted.
- A read of the data port is not issued on the same cycle as a read-pointer write.
- The register strobes are clean single-cycle pulses.

The directed stimulus keeps within these limits. Each register access is a single-cycle strobe placed on the falling edge. Pointer and count loads happen only while capture is disabled or before the trace stream starts. The trace stream is driven only after the enabling write has taken effect.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_WPTR  = 3'd2,
    RA_RPTR  = 3'd3,
    RA_DATA  = 3'd4,
    RA_TCNT  = 3'd5,
    RA_DEPTH = 3'd6,
    RA_WIDTH = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/trc_engine.sv
module trc_engine
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int AW  = $clog2(DEPTH),
  localparam int TCW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             trc_vld,
  input  logic [WIDTH-1:0] trc_word,
  input  logic             trc_trig,
  input  logic             wptr_we,
  input  logic             tcnt_we,
  input  logic [BUS_W-1:0] wdata,
  output logic             wr_en,
  output logic [WIDTH-1:0] wr_data,
  output logic [AW-1:0]    wptr,
  output logic [TCW-1:0]   tcnt,
  output logic             full,
  output logic             trig,
  output logic             done,
  output logic             fmt_empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic             active;
  logic             stg_vld, stg_vld_nx;
  logic [WIDTH-1:0] stg_data;
  logic [AW-1:0]    wptr_nx;
  logic [TCW-1:0]   tcnt_nx;
  logic             full_nx, trig_nx, done_nx;

  assign active    = en && !done;
  assign wr_en     = active && stg_vld;
  assign wr_data   = stg_data;
  assign fmt_empty = !stg_vld;

  always_comb begin
    stg_vld_nx = active && trc_vld;

    wptr_nx = wptr;
    if (wptr_we)    wptr_nx = wdata[AW-1:0];
    else if (wr_en) wptr_nx = (wptr == LAST) ? '0 : wptr + 1'b1;

    tcnt_nx = tcnt;
    if (tcnt_we)                               tcnt_nx = wdata[TCW-1:0];
    else if (trig && wr_en && tcnt != '0)      tcnt_nx = tcnt - 1'b1;

    full_nx = full;
    trig_nx = trig;
    done_nx = done;
    if (restart) begin
      full_nx = 1'b0;
      trig_nx = 1'b0;
      done_nx = 1'b0;
    end else begin
      if (wr_en && wptr == LAST) full_nx = 1'b1;
      if (active && trc_trig)    trig_nx = 1'b1;
      if (active) begin
        if (!trig && trc_trig && tcnt == '0)        done_nx = 1'b1;
        if (trig && tcnt == '0)                     done_nx = 1'b1;
        if (trig && wr_en && tcnt == TCW'(1))       done_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld <= 1'b0;
      wptr    <= '0;
      tcnt    <= '0;
      full    <= 1'b0;
      trig    <= 1'b0;
      done    <= 1'b0;
    end else begin
      stg_vld <= stg_vld_nx;
      wptr    <= wptr_nx;
      tcnt    <= tcnt_nx;
      full    <= full_nx;
      trig    <= trig_nx;
      done    <= done_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (stg_vld_nx) stg_data <= trc_word;
  end
endmodule

// File: rtl/trc_regif.sv
module trc_regif
  import trc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 24,
  parameter int PORT_W = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int TCW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              en,
  output logic              demux,
  output logic              restart,
  output logic              wptr_we,
  output logic              tcnt_we,
  output logic              data_re,
  output logic [AW-1:0]     rptr,
  input  logic [3:0]        status,
  input  logic [AW-1:0]     wptr,
  input  logic [TCW-1:0]    tcnt,
  input  logic [WIDTH-1:0]  ram_rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          ctrl_we, rptr_we;
  logic          en_nx, demux_nx;
  logic [AW-1:0] rptr_nx;

  assign ctrl_we = reg_wr && (reg_addr == RA_CTRL);
  assign wptr_we = reg_wr && (reg_addr == RA_WPTR);
  assign rptr_we = reg_wr && (reg_addr == RA_RPTR);
  assign tcnt_we = reg_wr && (reg_addr == RA_TCNT);
  assign data_re = reg_rd && (reg_addr == RA_DATA);
  assign restart = ctrl_we && reg_wdata[0];

  generate
    if (PORT_W == 8) begin : g_demux_ok
      assign demux_nx = ctrl_we ? reg_wdata[1] : demux;
    end else begin : g_demux_off
      assign demux_nx = 1'b0;
    end
  endgenerate

  always_comb begin
    en_nx = ctrl_we ? reg_wdata[0] : en;
    rptr_nx = rptr;
    if (rptr_we)      rptr_nx = reg_wdata[AW-1:0];
    else if (data_re) rptr_nx = (rptr == LAST) ? '0 : rptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      demux <= 1'b0;
      rptr  <= '0;
    end else begin
      en    <= en_nx;
      demux <= demux_nx;
      rptr  <= rptr_nx;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {{(BUS_W-2){1'b0}}, demux, en};
      RA_STAT:  reg_rdata = {{(BUS_W-4){1'b0}}, status};
      RA_WPTR:  reg_rdata = BUS_W'(wptr);
      RA_RPTR:  reg_rdata = BUS_W'(rptr);
      RA_DATA:  reg_rdata = BUS_W'(ram_rdata);
      RA_TCNT:  reg_rdata = BUS_W'(tcnt);
      RA_DEPTH: reg_rdata = BUS_W'(DEPTH);
      default:  reg_rdata = BUS_W'(WIDTH);
    endcase
  end
endmodule

// File: rtl/trc_capbuf.sv
module trc_capbuf
  import trc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 24,
  parameter int PORT_W = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int TCW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_vld,
  input  logic [WIDTH-1:0]  trc_word,
  input  logic              trc_trig,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata
);
  logic [1:0]       rst_sync;
  logic             rst_sn;
  logic             en, demux, restart, wptr_we, tcnt_we, data_re;
  logic             wr_en, full, trig, done, fmt_empty;
  logic [AW-1:0]    wptr, rptr;
  logic [TCW-1:0]   tcnt;
  logic [WIDTH-1:0] wr_data, ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  trc_regif #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PORT_W(PORT_W)) u_regif (
    .clk(clk), .rst_n(rst_sn), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .en(en), .demux(demux), .restart(restart), .wptr_we(wptr_we),
    .tcnt_we(tcnt_we), .data_re(data_re), .rptr(rptr),
    .status({fmt_empty, done, trig, full}), .wptr(wptr), .tcnt(tcnt),
    .ram_rdata(ram_rdata)
  );

  trc_engine #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_engine (
    .clk(clk), .rst_n(rst_sn), .en(en), .restart(restart),
    .trc_vld(trc_vld), .trc_word(trc_word), .trc_trig(trc_trig),
    .wptr_we(wptr_we), .tcnt_we(tcnt_we), .wdata(reg_wdata),
    .wr_en(wr_en), .wr_data(wr_data), .wptr(wptr), .tcnt(tcnt),
    .full(full), .trig(trig), .done(done), .fmt_empty(fmt_empty)
  );

  trc_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wptr), .wr_data(wr_data),
    .rd_addr(rptr), .rd_data(ram_rdata)
  );
endmodule

// File: rtl/trc_capbuf_chk.sv
module trc_capbuf_chk #(
  parameter int DEPTH = 16,
  localparam int AW  = $clog2(DEPTH),
  localparam int TCW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          restart,
  input logic          wr_en,
  input logic          wptr_we,
  input logic          data_re,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic [TCW-1:0] tcnt,
  input logic          full,
  input logic          trig,
  input logic          done,
  input logic          fmt_empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wptr_we) |=> (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1)));

  p_full_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !restart) |=> full);

  p_trig_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !trig) |=> !trig);

  p_no_write_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  p_done_after_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trig);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |=> fmt_empty);

  p_rptr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    data_re |=> (rptr == (($past(rptr) == LAST) ? '0 : $past(rptr) + 1'b1)));
endmodule

bind trc_capbuf trc_capbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sn), .en(en), .restart(restart), .wr_en(wr_en),
  .wptr_we(wptr_we), .data_re(data_re), .wptr(wptr), .rptr(rptr),
  .tcnt(tcnt), .full(full), .trig(trig), .done(done), .fmt_empty(fmt_empty)
);

// File: tb/trc_capbuf_bench.sv
module trc_capbuf_bench;
  localparam int DEPTH = 16;
  localparam int WIDTH = 24;

  logic             clk;
  logic             rst_n;
  logic             trc_vld;
  logic [WIDTH-1:0] trc_word;
  logic             trc_trig;
  logic             reg_wr, reg_rd;
  logic [2:0]       reg_addr;
  logic [31:0]      reg_wdata, reg_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  trc_capbuf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PORT_W(8)) u_trc_capbuf (
    .clk(clk), .rst_n(rst_n), .trc_vld(trc_vld), .trc_word(trc_word),
    .trc_trig(trc_trig), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_read(a, v);
    chk(req, v, exp);
  endtask

  task automatic drive_words(input int n, input logic [31:0] base, input int trig_at);
    for (int i = 0; i < n; i++) begin
      trc_vld = 1'b1; trc_word = WIDTH'(base + i); trc_trig = (i == trig_at);
      @(negedge clk);
    end
    trc_vld = 1'b0; trc_trig = 1'b0;
  endtask

  task automatic t_reset;
    read_chk("R1 ctrl", 3'd0, 32'h0);
    read_chk("R1 status", 3'd1, 32'h8);
    read_chk("R1 wptr", 3'd2, 32'h0);
    read_chk("R1 rptr", 3'd3, 32'h0);
    read_chk("R1 tcnt", 3'd5, 32'h0);
    read_chk("R2 depth", 3'd6, DEPTH);
    read_chk("R2 width", 3'd7, WIDTH);
  endtask

  task automatic t_basic;
    reg_write(3'd2, 0);
    reg_write(3'd5, 3);
    reg_write(3'd0, 1);
    drive_words(10, 32'h100, 4);
    repeat (2) @(negedge clk);
    read_chk("R6 status complete", 3'd1, 32'hE);
    read_chk("R6 wptr frozen", 3'd2, 32'd7);
    read_chk("R6 tcnt zero", 3'd5, 32'd0);
    reg_write(3'd3, 0);
    for (int j = 0; j < 7; j++) read_chk("R3 data order", 3'd4, 32'h100 + j);
    read_chk("R12 rptr advanced", 3'd3, 32'd7);
  endtask

  task automatic t_wrap;
    reg_write(3'd2, 0);
    reg_write(3'd5, 5);
    reg_write(3'd0, 1);
    drive_words(20, 32'h200, 18);
    repeat (2) @(negedge clk);
    read_chk("R4 wrapped status", 3'd1, 32'hB);
    read_chk("R3 wptr modulo", 3'd2, 32'd4);
    reg_write(3'd0, 0);
    read_chk("R9 flags kept", 3'd1, 32'hB);
    drive_words(3, 32'h300, -1);
    repeat (2) @(negedge clk);
    read_chk("R9 wptr frozen", 3'd2, 32'd4);
    read_chk("R6 tcnt counted", 3'd5, 32'd3);
    reg_write(3'd3, 4);
    for (int j = 0; j < DEPTH; j++) read_chk("R12 oldest first", 3'd4, 32'h204 + j);
    read_chk("R12 rptr wrap", 3'd3, 32'd4);
  endtask

  task automatic t_ignore;
    reg_write(3'd0, 1);
    read_chk("R10 flags cleared", 3'd1, 32'h8);
    reg_write(3'd0, 0);
    @(negedge clk);
    trc_trig = 1'b1;
    @(negedge clk);
    trc_trig = 1'b0;
    repeat (2) @(negedge clk);
    read_chk("R5 trigger ignored", 3'd1, 32'h8);
  endtask

  task automatic t_zero_count;
    reg_write(3'd2, 0);
    reg_write(3'd5, 0);
    reg_write(3'd0, 1);
    trc_vld = 1'b1; trc_word = 24'h400; trc_trig = 1'b1;
    reg_rd = 1'b1; reg_addr = 3'd1;
    @(posedge clk);
    #2 chk("R7 complete with trigger", reg_rdata, 32'h6);
    trc_vld = 1'b0; trc_trig = 1'b0;
    @(posedge clk);
    #2 chk("R8 staging flushed", reg_rdata, 32'hE);
    @(negedge clk);
    reg_rd = 1'b0;
    read_chk("R7 no write", 3'd2, 32'd0);
  endtask

  task automatic t_regs;
    reg_write(3'd0, 2);
    read_chk("R11 demux stored", 3'd0, 32'h2);
    reg_write(3'd0, 0);
    read_chk("R11 demux cleared", 3'd0, 32'h0);
    reg_write(3'd2, 9);
    read_chk("R13 wptr write", 3'd2, 32'd9);
    reg_write(3'd5, 12);
    read_chk("R13 tcnt write", 3'd5, 32'd12);
  endtask

  initial begin
    trc_vld = 0; trc_word = '0; trc_trig = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_ignore();
    t_zero_count();
    t_regs();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule